// File: doc/BRIEF.md
# Byte-Packet Local Bus Master

This block turns a framed byte stream into transfers on a simple 32-bit local bus. A packet opens with the byte 0xF0, then carries a destination slot byte, a byte whose upper nibble selects a sub-slot and whose lower nibble holds a command, and a payload length byte (0 to 255). The payload follows at once. Bytes are collected most-significant-first into 32-bit words. The first payload word is the byte address. For writes, each later word is written to the bus. For reads, the second word is the number of words to read.

The block answers to its own slot (0x00 by default) and to the broadcast slot 0xFF. It performs bus work only for sub-slot 0x0. Incrementing commands step the address by four bytes after each word. Repeat commands keep every word on the one starting address. Read results leave on a byte output stream, most significant byte first. A start or stop marker resets the header parser at any point. Packets that are not meant for this block are consumed in full, so their payload bytes are never mistaken for a new header.

Top module: `pkt_lb_master`

## Requirements
- R1: While no packet is open, every byte other than 0xF0 (idle 0xFF included) is ignored and causes no bus or output activity.
- R2: The byte after 0xF0 is the slot. Only 0x00 and 0xFF select this block, and 0xFE never does. A packet for any other slot is consumed to the end of its stated length, with no activity, even if its payload contains 0xF0.
- R3: In the third byte, bits 7:4 are the sub-slot and bits 3:0 are the command: 0x0 write, 0x1 read, 0x2 write repeat, 0x3 read repeat. A non-zero sub-slot or any other command causes no activity.
- R4: The fourth byte is the payload length. The first four payload bytes form the start address, big-endian.
- R5: For command 0x0, each following group of four bytes is one big-endian data word. Each word gives a one-cycle lb_wr pulse in the cycle after its fourth byte is taken. The first word goes to the start address, and each later word goes 4 higher.
- R6: For command 0x2, every data word is written to the start address.
- R7: For command 0x1, payload bytes 4..7 form a big-endian word count N. The block issues N one-cycle lb_rd pulses at the start address, then at +4, +8 and so on. Each read waits for lb_rvalid. In the cycle after lb_rvalid is taken, the four bytes of lb_rdata appear on tx_data, MSB first, over four consecutive tx_valid cycles. The next read follows only after that.
- R8: For command 0x3, all N reads use the start address. A count of zero gives no read.
- R9: Bytes left at the end of a payload that do not fill a word are dropped. A length of 0 gives no activity. The next packet starts a fresh word.
- R10: A pulse on rx_start or rx_stop returns the parser to idle and drops any partial word. It also ends an active read sequence, so no further lb_rd is issued.
- R11: rst_n low forces lb_wr, lb_rd and tx_valid low at once. Release takes effect after two clock edges.
- R12: lb_wr and lb_rd are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_start | input | 1 | Start marker; resets the parser |
| rx_stop | input | 1 | Stop marker; resets the parser |
| rx_valid | input | 1 | rx_data holds a byte this cycle |
| rx_data | input | 8 | Incoming byte |
| lb_wr | output | 1 | One-cycle write strobe |
| lb_rd | output | 1 | One-cycle read request |
| lb_addr | output | 32 | Bus byte address |
| lb_wdata | output | 32 | Write data |
| lb_rdata | input | 32 | Read data, taken with lb_rvalid |
| lb_rvalid | input | 1 | Read data valid |
| tx_valid | output | 1 | tx_data holds a result byte |
| tx_data | output | 8 | Result byte stream, MSB first |

## Verification
- **Write timing:** a write strobe is due exactly one cycle after the clock edge that takes the fourth byte of its word. The bench records the cycle index at which it drives every payload byte and the cycle index at which each strobe is seen, and it requires the second to equal the first plus one.
- **Read timing:** the first result byte is due one cycle after the edge that takes lb_rvalid, and the other three follow on the next three cycles. The bench's bus model logs its lb_rvalid cycle and compares each logged tx byte's cycle against that.
- **Sampling:** inputs change on the falling edge and outputs are read there too, so each recorded index points at a single rising edge.

// File: rtl/pkt_lb_pkg.sv
package pkt_lb_pkg;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_SLOT,
    PS_CMD,
    PS_LEN,
    PS_BODY
  } parse_st_t;

  typedef enum logic [1:0] {
    SQ_COLLECT,
    SQ_RD_WAIT,
    SQ_RD_SEND
  } seq_st_t;

  // command nibble bit 0 selects read, bit 1 selects fixed address
  localparam int unsigned OP_READ_BIT = 0;
  localparam int unsigned OP_REP_BIT  = 1;

endpackage

// File: rtl/pkt_rst_sync.sv
module pkt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pkt_hdr_parse.sv
module pkt_hdr_parse
  import pkt_lb_pkg::*;
#(
  parameter logic [7:0] START_CODE = 8'hF0,
  parameter logic [7:0] SLOT_ID    = 8'h00,
  parameter logic [7:0] BCAST_ID   = 8'hFF,
  parameter logic [7:0] NULL_ID    = 8'hFE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_start,
  input  logic       rx_stop,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       pay_vld,
  output logic [7:0] pay_byte,
  output logic       pay_last,
  output logic       abort,
  output logic [1:0] op
);

  parse_st_t  st_q, st_d;
  logic [7:0] rem_q, rem_d;
  logic       hit_q, hit_d;
  logic       act_q, act_d;
  logic [1:0] op_q, op_d;

  always_comb begin
    st_d     = st_q;
    rem_d    = rem_q;
    hit_d    = hit_q;
    act_d    = act_q;
    op_d     = op_q;
    pay_vld  = 1'b0;
    pay_last = 1'b0;
    abort    = rx_start | rx_stop;
    if (abort) begin
      st_d = PS_IDLE;
    end else if (rx_valid) begin
      case (st_q)
        PS_IDLE: begin
          if (rx_data == START_CODE) st_d = PS_SLOT;
        end
        PS_SLOT: begin
          hit_d = ((rx_data == SLOT_ID) || (rx_data == BCAST_ID)) &&
                  (rx_data != NULL_ID);
          st_d  = PS_CMD;
        end
        PS_CMD: begin
          act_d = hit_q && (rx_data[7:4] == 4'h0) && (rx_data[3:2] == 2'b00);
          op_d  = rx_data[1:0];
          st_d  = PS_LEN;
        end
        PS_LEN: begin
          rem_d = rx_data;
          st_d  = (rx_data == 8'h00) ? PS_IDLE : PS_BODY;
        end
        PS_BODY: begin
          pay_vld = act_q;
          rem_d   = rem_q - 8'd1;
          if (rem_q == 8'd1) begin
            st_d     = PS_IDLE;
            pay_last = act_q;
          end
        end
        default: st_d = PS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_IDLE;
      rem_q <= '0;
      hit_q <= 1'b0;
      act_q <= 1'b0;
      op_q  <= '0;
    end else begin
      st_q  <= st_d;
      rem_q <= rem_d;
      hit_q <= hit_d;
      act_q <= act_d;
      op_q  <= op_d;
    end
  end

  assign pay_byte = rx_data;
  assign op       = op_q;

  // a marker always leaves the parser idle on the next cycle
  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_start || rx_stop) |=> (st_q == PS_IDLE));

endmodule

// File: rtl/lb_burst_seq.sv
module lb_burst_seq
  import pkt_lb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pay_vld,
  input  logic [7:0]        pay_byte,
  input  logic              pay_last,
  input  logic              abort,
  input  logic [1:0]        op,
  input  logic              lb_rvalid,
  input  logic [DATA_W-1:0] lb_rdata,
  input  logic              ser_busy,
  output logic              lb_wr,
  output logic              lb_rd,
  output logic [ADDR_W-1:0] lb_addr,
  output logic [DATA_W-1:0] lb_wdata,
  output logic              ser_load,
  output logic [DATA_W-1:0] ser_word
);

  localparam int unsigned NB   = DATA_W / 8;
  localparam int unsigned BC_W = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(NB);
  localparam logic [BC_W-1:0]   LAST_BYTE = BC_W'(NB - 1);

  seq_st_t           st_q, st_d;
  logic [DATA_W-1:0] sr_q, sr_d;
  logic [BC_W-1:0]   bc_q, bc_d;
  logic [1:0]        wi_q, wi_d;
  logic [ADDR_W-1:0] ad_q, ad_d;
  logic [ADDR_W-1:0] la_q, la_d;
  logic [DATA_W-1:0] left_q, left_d;
  logic [DATA_W-1:0] wd_q, wd_d;
  logic              wr_q, wr_d;
  logic              rd_q, rd_d;

  logic [DATA_W-1:0] word;
  logic              word_done;
  logic              op_read;
  logic              op_rep;

  assign op_read   = op[OP_READ_BIT];
  assign op_rep    = op[OP_REP_BIT];
  assign word      = {sr_q[DATA_W-9:0], pay_byte};
  assign word_done = pay_vld && (bc_q == LAST_BYTE);
  assign ser_load  = (st_q == SQ_RD_WAIT) && lb_rvalid && !abort;
  assign ser_word  = lb_rdata;

  always_comb begin
    st_d   = st_q;
    sr_d   = sr_q;
    bc_d   = bc_q;
    wi_d   = wi_q;
    ad_d   = ad_q;
    la_d   = la_q;
    left_d = left_q;
    wd_d   = wd_q;
    wr_d   = 1'b0;
    rd_d   = 1'b0;
    case (st_q)
      SQ_COLLECT: begin
        if (pay_vld) begin
          sr_d = word;
          bc_d = bc_q + 1'b1;
          if (word_done) begin
            if (wi_q != 2'd2) wi_d = wi_q + 2'd1;
            if (wi_q == 2'd0) begin
              ad_d = word[ADDR_W-1:0];
            end else if (!op_read) begin
              wr_d = 1'b1;
              la_d = ad_q;
              wd_d = word;
              if (!op_rep) ad_d = ad_q + STEP;
            end else if ((wi_q == 2'd1) && (word != '0)) begin
              rd_d   = 1'b1;
              la_d   = ad_q;
              left_d = word;
              st_d   = SQ_RD_WAIT;
            end
          end
        end
      end
      SQ_RD_WAIT: begin
        if (lb_rvalid) begin
          left_d = left_q - 1'b1;
          if (!op_rep) ad_d = ad_q + STEP;
          st_d = SQ_RD_SEND;
        end
      end
      SQ_RD_SEND: begin
        if (!ser_busy) begin
          if (left_q == '0) begin
            st_d = SQ_COLLECT;
          end else begin
            rd_d = 1'b1;
            la_d = ad_q;
            st_d = SQ_RD_WAIT;
          end
        end
      end
      default: st_d = SQ_COLLECT;
    endcase
    if (pay_last || abort) begin
      bc_d = '0;
      wi_d = 2'd0;
    end
    if (abort) begin
      st_d = SQ_COLLECT;
      rd_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_COLLECT;
      sr_q   <= '0;
      bc_q   <= '0;
      wi_q   <= '0;
      ad_q   <= '0;
      la_q   <= '0;
      left_q <= '0;
      wd_q   <= '0;
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      sr_q   <= sr_d;
      bc_q   <= bc_d;
      wi_q   <= wi_d;
      ad_q   <= ad_d;
      la_q   <= la_d;
      left_q <= left_d;
      wd_q   <= wd_d;
      wr_q   <= wr_d;
      rd_q   <= rd_d;
    end
  end

  assign lb_wr    = wr_q;
  assign lb_rd    = rd_q;
  assign lb_addr  = la_q;
  assign lb_wdata = wd_q;

  assert_wr_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lb_wr |=> !lb_wr);

  assert_rd_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lb_rd |=> !lb_rd);

  assert_no_overlap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(lb_wr && lb_rd));

  // running address is one word ahead of the strobed one when incrementing
  assert_inc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_wr && !op_rep) |-> (ad_q == lb_addr + STEP));

  assert_rep_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_wr && op_rep) |-> (ad_q == lb_addr));

  // a new result word never lands while bytes of the last are still leaving
  assert_load_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ser_load |-> !ser_busy);

endmodule

// File: rtl/rd_byte_ser.sv
module rd_byte_ser #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] word,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              busy
);

  localparam int unsigned NB = DATA_W / 8;
  localparam int unsigned CW = $clog2(NB + 1);

  logic [DATA_W-1:0] sr_q, sr_d;
  logic [CW-1:0]     cnt_q, cnt_d;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (load) begin
      sr_d  = word;
      cnt_d = CW'(NB);
    end else if (cnt_q != '0) begin
      sr_d  = {sr_q[DATA_W-9:0], 8'h00};
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign tx_valid = (cnt_q != '0);
  assign busy     = (cnt_q != '0);
  assign tx_data  = sr_q[DATA_W-1 -: 8];

  // once a word starts leaving, its bytes run back to back
  assert_tx_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |=> tx_valid);

endmodule

// File: rtl/pkt_lb_master.sv
module pkt_lb_master #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter logic [7:0]  START_CODE = 8'hF0,
  parameter logic [7:0]  SLOT_ID    = 8'h00,
  parameter logic [7:0]  BCAST_ID   = 8'hFF,
  parameter logic [7:0]  NULL_ID    = 8'hFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_start,
  input  logic              rx_stop,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              lb_wr,
  output logic              lb_rd,
  output logic [ADDR_W-1:0] lb_addr,
  output logic [DATA_W-1:0] lb_wdata,
  input  logic [DATA_W-1:0] lb_rdata,
  input  logic              lb_rvalid,
  output logic              tx_valid,
  output logic [7:0]        tx_data
);

  logic              rst_int_n;
  logic              pay_vld;
  logic [7:0]        pay_byte;
  logic              pay_last;
  logic              abort;
  logic [1:0]        op;
  logic              ser_load;
  logic [DATA_W-1:0] ser_word;
  logic              ser_busy;

  pkt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pkt_hdr_parse #(
    .START_CODE (START_CODE),
    .SLOT_ID    (SLOT_ID),
    .BCAST_ID   (BCAST_ID),
    .NULL_ID    (NULL_ID)
  ) u_parse (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rx_start (rx_start),
    .rx_stop  (rx_stop),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .pay_vld  (pay_vld),
    .pay_byte (pay_byte),
    .pay_last (pay_last),
    .abort    (abort),
    .op       (op)
  );

  lb_burst_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pay_vld   (pay_vld),
    .pay_byte  (pay_byte),
    .pay_last  (pay_last),
    .abort     (abort),
    .op        (op),
    .lb_rvalid (lb_rvalid),
    .lb_rdata  (lb_rdata),
    .ser_busy  (ser_busy),
    .lb_wr     (lb_wr),
    .lb_rd     (lb_rd),
    .lb_addr   (lb_addr),
    .lb_wdata  (lb_wdata),
    .ser_load  (ser_load),
    .ser_word  (ser_word)
  );

  rd_byte_ser #(.DATA_W(DATA_W)) u_ser (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (ser_load),
    .word     (ser_word),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .busy     (ser_busy)
  );

endmodule

// File: tb/sim_pkt_lb_master.sv
module sim_pkt_lb_master;

  logic        clk = 1'b0;
  logic        rst_n, rx_start, rx_stop, rx_valid;
  logic [7:0]  rx_data;
  logic        lb_wr, lb_rd, lb_rvalid, tx_valid;
  logic [31:0] lb_addr, lb_wdata, lb_rdata;
  logic [7:0]  tx_data;

  always #2 clk = ~clk;

  pkt_lb_master u0 (
    .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_stop(rx_stop),
    .rx_valid(rx_valid), .rx_data(rx_data), .lb_wr(lb_wr), .lb_rd(lb_rd),
    .lb_addr(lb_addr), .lb_wdata(lb_wdata), .lb_rdata(lb_rdata),
    .lb_rvalid(lb_rvalid), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int dcyc = 0;
  int lat = 0;
  int overlap = 0;
  bit finished = 0;

  logic [31:0] wa [0:63];
  logic [31:0] wd [0:63];
  int          wc [0:63];
  int          nw;
  logic [31:0] ra [0:63];
  int          nr;
  int          rvc [0:63];
  int          rd_seq;
  logic [7:0]  tq [0:255];
  int          tc [0:255];
  int          ntx;
  bit          pend;
  int          pwait;
  logic [31:0] paddr;
  logic [7:0]  pb [0:31];
  int          bcyc [0:31];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] rd_model(input logic [31:0] a, input int k);
    return (a * 32'h9E3779B1) ^ (32'(k) << 5) ^ 32'h0BADF00D;
  endfunction

  // bus model and output logger, all on the falling edge
  always @(negedge clk) begin
    lb_rvalid = 1'b0;
    if (rst_n) begin
      if (lb_wr && lb_rd) overlap++;
      if (lb_wr) begin
        if (nw < 64) begin wa[nw] = lb_addr; wd[nw] = lb_wdata; wc[nw] = cyc; end
        nw++;
      end
      if (lb_rd) begin
        if (nr < 64) ra[nr] = lb_addr;
        nr++;
        pend = 1; paddr = lb_addr; pwait = lat;
      end
      if (pend) begin
        if (pwait == 0) begin
          lb_rvalid = 1'b1;
          lb_rdata  = rd_model(paddr, rd_seq);
          if (rd_seq < 64) rvc[rd_seq] = cyc;
          rd_seq++;
          pend = 0;
        end else begin
          pwait--;
        end
      end
      if (tx_valid) begin
        if (ntx < 256) begin tq[ntx] = tx_data; tc[ntx] = cyc; end
        ntx++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_logs();
    @(posedge clk);
    nw = 0; nr = 0; ntx = 0; rd_seq = 0; pend = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b; dcyc = cyc;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic marker(input bit use_stop);
    @(negedge clk);
    if (use_stop) rx_stop = 1'b1; else rx_start = 1'b1;
    @(negedge clk);
    rx_start = 1'b0; rx_stop = 1'b0;
  endtask

  task automatic put_word(input int at, input logic [31:0] w);
    pb[at] = w[31:24]; pb[at+1] = w[23:16]; pb[at+2] = w[15:8]; pb[at+3] = w[7:0];
  endtask

  task automatic send_pkt(input logic [7:0] slot, input logic [7:0] sc, input int len);
    send_byte(8'hF0);
    send_byte(slot);
    send_byte(sc);
    send_byte(8'(len));
    for (int i = 0; i < len; i++) begin
      send_byte(pb[i]);
      bcyc[i] = dcyc;
    end
  endtask

  function automatic logic [31:0] wdat(input int id, input int k);
    return 32'hD1C0_0000 ^ (32'(id) << 8) ^ 32'(k * 17 + 3);
  endfunction

  task automatic run_case(input logic [7:0] slot, input logic [3:0] sub,
                          input logic [3:0] cmd, input int n, input int l, input int id);
    logic [31:0] base, ea, rw;
    int          len;
    bit          isrd, rep, hit, act;
    clear_logs();
    lat  = l;
    base = 32'h4000_0000 | (32'(id) << 4);
    isrd = (cmd == 4'h1) || (cmd == 4'h3);
    rep  = (cmd == 4'h2) || (cmd == 4'h3);
    len  = isrd ? 8 : 4 + 4 * n;
    put_word(0, base);
    if (isrd) put_word(4, 32'(n));
    else for (int k = 0; k < n; k++) put_word(4 + 4 * k, wdat(id, k));
    send_pkt(slot, {sub, cmd}, len);
    repeat (n * (l + 14) + 12) @(negedge clk);
    hit = (slot == 8'h00) || (slot == 8'hFF);
    act = hit && (sub == 4'h0) && (cmd <= 4'h3);
    if (!act) begin
      // R2 / R3: nothing on bus or stream
      chk(hit ? "R3 inactive" : "R2 inactive", 32'(nw + nr + ntx), 32'd0);
    end else if (!isrd) begin
      chk(rep ? "R6 write count" : "R5 write count", 32'(nw), 32'(n));
      for (int k = 0; k < n && k < nw; k++) begin
        ea = rep ? base : base + 32'(4 * k);
        chk(k == 0 ? "R4 start address" : (rep ? "R6 address" : "R5 address"), wa[k], ea);
        chk("R5 data", wd[k], wdat(id, k));
        chk("R5 strobe cycle", 32'(wc[k]), 32'(bcyc[4 + 4 * k + 3] + 1));
      end
    end else begin
      chk(n == 0 ? "R8 zero count" : "R7 read count", 32'(nr), 32'(n));
      chk("R7 byte count", 32'(ntx), 32'(4 * n));
      for (int k = 0; k < n && k < nr && 4 * k + 3 < ntx; k++) begin
        ea = rep ? base : base + 32'(4 * k);
        chk(rep ? "R8 address" : "R7 address", ra[k], ea);
        rw = rd_model(ea, k);
        for (int j = 0; j < 4; j++) begin
          chk("R7 byte value", 32'(tq[4 * k + j]), 32'(rw[31 - 8 * j -: 8]));
          chk("R7 byte cycle", 32'(tc[4 * k + j]), 32'(rvc[k] + 1 + j));
        end
      end
    end
  endtask

  task automatic one_write(input logic [31:0] a, input logic [31:0] d);
    put_word(0, a); put_word(4, d);
    send_pkt(8'h00, 8'h00, 8);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] slots [0:4];
    logic [3:0] subs  [0:2];
    int id;
    slots[0] = 8'h00; slots[1] = 8'hFF; slots[2] = 8'hFE; slots[3] = 8'h12; slots[4] = 8'h01;
    subs[0] = 4'h0; subs[1] = 4'h1; subs[2] = 4'hF;
    rst_n = 1'b0; rx_start = 1'b0; rx_stop = 1'b0; rx_valid = 1'b0; rx_data = 8'h00;
    lb_rvalid = 1'b0; lb_rdata = '0;
    nw = 0; nr = 0; ntx = 0; rd_seq = 0; pend = 0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 reset outputs", {29'd0, lb_wr, lb_rd, tx_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: idle and junk bytes ahead of a real packet
    clear_logs();
    send_byte(8'hFF); send_byte(8'hFF); send_byte(8'h00); send_byte(8'h00);
    send_byte(8'h04); send_byte(8'h12);
    repeat (4) @(negedge clk);
    chk("R1 junk ignored", 32'(nw + nr + ntx), 32'd0);
    one_write(32'h0000_0040, 32'hCAFE_0001);
    chk("R1 write after junk", 32'(nw), 32'd1);
    chk("R1 write data", wd[0], 32'hCAFE_0001);

    // R2: nested header inside a foreign packet payload
    clear_logs();
    pb[0] = 8'hF0; pb[1] = 8'h00; pb[2] = 8'h00; pb[3] = 8'h08;
    put_word(4, 32'h0000_0080); put_word(8, 32'h1111_2222); put_word(12, 32'h3333_4444);
    send_pkt(8'h12, 8'h00, 16);
    repeat (6) @(negedge clk);
    chk("R2 foreign payload", 32'(nw), 32'd0);

    // R9: trailing partial word, then a clean packet
    clear_logs();
    put_word(0, 32'h0000_0100); put_word(4, 32'hAAAA_5555); pb[8] = 8'h77; pb[9] = 8'h66;
    send_pkt(8'h00, 8'h00, 10);
    repeat (6) @(negedge clk);
    chk("R9 partial dropped", 32'(nw), 32'd1);
    send_pkt(8'h00, 8'h00, 0);
    repeat (4) @(negedge clk);
    chk("R9 zero length", 32'(nw), 32'd1);
    one_write(32'h0000_0200, 32'h0BAD_BEEF);
    chk("R9 fresh word addr", wa[1], 32'h0000_0200);
    chk("R9 fresh word data", wd[1], 32'h0BAD_BEEF);

    // R10: markers drop a partial packet
    for (int m = 0; m < 2; m++) begin
      clear_logs();
      send_byte(8'hF0); send_byte(8'h00); send_byte(8'h00); send_byte(8'h08);
      send_byte(8'h00); send_byte(8'h00); send_byte(8'h03); send_byte(8'h00);
      send_byte(8'h99); send_byte(8'h88);
      marker(m == 1);
      one_write(32'h0000_0300 + 32'(m), 32'h5A5A_0000 + 32'(m));
      chk("R10 one write after marker", 32'(nw), 32'd1);
      chk("R10 address after marker", wa[0], 32'h0000_0300 + 32'(m));
      chk("R10 data after marker", wd[0], 32'h5A5A_0000 + 32'(m));
    end

    // R10: marker ends a read sequence
    clear_logs();
    lat = 8;
    put_word(0, 32'h0000_0400); put_word(4, 32'd3);
    send_pkt(8'h00, 8'h01, 8);
    while (nr == 0) @(negedge clk);
    marker(1'b0);
    repeat (40) @(negedge clk);
    chk("R10 read aborted", 32'(nr), 32'd1);
    chk("R10 no bytes after abort", 32'(ntx), 32'd0);

    // R11: asynchronous reset in the middle of a read
    clear_logs();
    lat = 0;
    put_word(0, 32'h0000_0500); put_word(4, 32'd4);
    send_pkt(8'h00, 8'h03, 8);
    while (ntx == 0) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R11 async clear", {29'd0, lb_wr, lb_rd, tx_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_case(8'h00, 4'h0, 4'h1, 2, 1, 900);

    // sweep over slot, sub-slot, command, word count and read latency
    id = 0;
    for (int s = 0; s < 5; s++)
      for (int u = 0; u < 3; u++)
        for (int c = 0; c < 6; c++)
          for (int n = 0; n < 3; n++) begin
            run_case(slots[s], subs[u], 4'(c), n, (n + c) % 3, id);
            id++;
          end

    chk("R12 no overlap", 32'(overlap), 32'd0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule